// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

A compact single-accumulator processor core. It walks a fixed chain of timing states to pull an instruction word from a synchronous single-port memory, optionally chase one level of pointer to form the operand address, carry out the operation, and then look for a pending interrupt before fetching again. Words are 16 bits wide and addresses 12 bits wide. The memory returns read data one clock after the address is presented.

Each 16-bit instruction holds an indirect flag in its top bit, a 3-bit operation field below it, and a 12-bit address in the low bits. Seven operation values touch memory. The eighth (all ones) marks a control word whose low twelve bits carry a single set bit naming the action. The top bit of such a word chooses between accumulator-control actions and port actions. An 8-bit input port latches a byte when its strobe is pulsed and raises an input-ready flag. A strobe from the output device raises an output-ready flag. A halt output reports that sequencing has stopped.

Top module: `acc_sequencer`

## Requirements
- R1: Synchronous active-high reset clears the program counter, accumulator, carry bit, interrupt enable, interrupt request and both port flags. After reset `halted` is 0, `out_data` is 0, `mem_we` is 0 and the first fetch drives `mem_addr` = 0.
- R2: Word layout: bit 15 is the indirect flag, bits 14..12 the operation, bits 11..0 the address. With the flag at 0, op 000 ANDs the memory word into the accumulator, 001 adds it and puts the carry-out in the carry bit, 010 loads it, and 011 stores the accumulator to it. Each of these takes 4 clocks.
- R3: With the indirect flag at 1 on ops 000..110, the word read at the address field supplies the effective address in its low 12 bits. This adds 2 clocks, so the instruction takes 6.
- R4: Op 100 jumps to the effective address. Op 101 writes the return address (the address after the call, zero-extended) at the effective address and continues at effective address + 1.
- R5: Op 110 writes the memory word plus one back to the same location. When that result is 0, the next instruction is skipped.
- R6: Control words with bit 15 at 0: 0x7800 clears the accumulator, 0x7400 clears the carry bit, 0x7080 rotates {carry, accumulator} right by one, 0x7040 rotates it left by one, and 0x7020 increments the accumulator. Each takes 3 clocks. When several bits are set, the highest-numbered one acts.
- R7: 0x7001 stops sequencing. `halted` then stays 1 and no memory write occurs until reset.
- R8: A pulse on `in_strobe` captures `in_data` and sets the input flag. A pulse on `out_ack` sets the output flag. 0xF800 loads the accumulator with the captured byte zero-extended and clears the input flag. 0xF400 copies the accumulator's low byte to `out_data` and clears the output flag.
- R9: 0xF200 skips the next instruction when the input flag is 1. 0xF100 skips it when the output flag is 1.
- R10: 0xF080 sets and 0xF040 clears interrupt enable. An interrupt request is latched when an instruction passes its operand or execute states while enable and either port flag are 1, using the values held before that instruction acts. At the next instruction boundary the core takes 2 clocks to write the program counter to address 0, load the program counter with 1, and clear both enable and request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| in_data | input | 8 | Input port byte |
| in_strobe | input | 1 | Input byte ready pulse |
| out_data | output | 8 | Output port byte |
| out_ack | input | 1 | Output device ready pulse |
| halted | output | 1 | Sequencing stopped |

## Verification
Each instruction has a fixed cost: 4 clocks for direct memory operations, 6 for indirect ones, 3 for control words, and 2 for an interrupt entry. A run's total clocks from reset release to the rise of `halted` is therefore the sum of the costs of the instructions the bench's own instruction-level model retires. The bench compares that sum exactly with the count of edges it observes, sampling on the falling edge after each rising edge. Architectural results are compared only after the halt: the whole memory image and `out_data` against the model. The port strobes are pulsed only in the first clock after reset, so the flag values that the model assumes before the first instruction hold in the hardware.

// File: rtl/acc_sequencer.sv
module acc_sequencer #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  input  logic [BW-1:0] in_data,
  input  logic          in_strobe,
  output logic [BW-1:0] out_data,
  input  logic          out_ack,
  output logic          halted
);
  localparam int OPW = DW - AW - 1;
  localparam logic [OPW-1:0] OP_AND  = 3'd0;
  localparam logic [OPW-1:0] OP_ADD  = 3'd1;
  localparam logic [OPW-1:0] OP_LOAD = 3'd2;
  localparam logic [OPW-1:0] OP_STOR = 3'd3;
  localparam logic [OPW-1:0] OP_JUMP = 3'd4;
  localparam logic [OPW-1:0] OP_CALL = 3'd5;
  localparam logic [OPW-1:0] OP_INCS = 3'd6;
  localparam logic [OPW-1:0] OP_CTRL = 3'd7;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_IND, S_INDD, S_OPER, S_EXEC, S_INTR, S_HALT
  } state_t;

  state_t        state;
  logic [AW-1:0] pc, ar;
  logic [OPW:0]  ir_top;
  logic [DW-1:0] ac;
  logic          e_bit, int_en, irq_r, in_flag, out_flag;
  logic [BW-1:0] in_reg, out_reg;

  wire [OPW-1:0] op      = ir_top[OPW-1:0];
  wire           ind     = ir_top[OPW];
  wire [DW-1:0]  incd    = mem_rdata + 1'b1;
  wire           setter  = state inside {S_IND, S_INDD, S_OPER, S_EXEC};
  wire [DW-1:0]  pc_word = {{(DW-AW){1'b0}}, pc};

  assign halted   = (state == S_HALT);
  assign out_data = out_reg;

  always_comb begin
    mem_addr  = ar;
    mem_wdata = ac;
    mem_we    = 1'b0;
    case (state)
      S_FETCH: mem_addr = pc;
      S_INTR: begin
        mem_addr  = '0;
        mem_wdata = pc_word;
        mem_we    = 1'b1;
      end
      S_EXEC: begin
        if (op == OP_STOR) mem_we = 1'b1;
        if (op == OP_CALL) begin mem_we = 1'b1; mem_wdata = pc_word; end
        if (op == OP_INCS) begin mem_we = 1'b1; mem_wdata = incd; end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_FETCH;
      pc       <= '0;
      ar       <= '0;
      ir_top   <= '0;
      ac       <= '0;
      e_bit    <= 1'b0;
      int_en   <= 1'b0;
      irq_r    <= 1'b0;
      in_flag  <= 1'b0;
      out_flag <= 1'b0;
      in_reg   <= '0;
      out_reg  <= '0;
    end else begin
      if (setter && int_en && (in_flag || out_flag)) irq_r <= 1'b1;
      case (state)
        S_FETCH: state <= irq_r ? S_INTR : S_DECODE;
        S_DECODE: begin
          ir_top <= mem_rdata[DW-1 -: OPW+1];
          ar     <= mem_rdata[AW-1:0];
          pc     <= pc + 1'b1;
          if (mem_rdata[DW-2 -: OPW] == OP_CTRL) state <= S_EXEC;
          else if (mem_rdata[DW-1])              state <= S_IND;
          else                                   state <= S_OPER;
        end
        S_IND:  state <= S_INDD;
        S_INDD: begin
          ar    <= mem_rdata[AW-1:0];
          state <= S_OPER;
        end
        S_OPER: state <= S_EXEC;
        S_EXEC: begin
          state <= S_FETCH;
          case (op)
            OP_AND:  ac <= ac & mem_rdata;
            OP_ADD:  {e_bit, ac} <= {1'b0, ac} + {1'b0, mem_rdata};
            OP_LOAD: ac <= mem_rdata;
            OP_STOR: ;
            OP_JUMP: pc <= ar;
            OP_CALL: pc <= ar + 1'b1;
            OP_INCS: if (incd == '0) pc <= pc + 1'b1;
            default: begin
              if (!ind) begin
                if (ar[AW-1])      ac <= '0;
                else if (ar[AW-2]) e_bit <= 1'b0;
                else if (ar[AW-5]) begin ac <= {e_bit, ac[DW-1:1]}; e_bit <= ac[0]; end
                else if (ar[AW-6]) begin ac <= {ac[DW-2:0], e_bit}; e_bit <= ac[DW-1]; end
                else if (ar[AW-7]) ac <= ac + 1'b1;
                else if (ar[0])    state <= S_HALT;
              end else begin
                if (ar[AW-1]) begin
                  ac      <= {{(DW-BW){1'b0}}, in_reg};
                  in_flag <= 1'b0;
                end else if (ar[AW-2]) begin
                  out_reg  <= ac[BW-1:0];
                  out_flag <= 1'b0;
                end else if (ar[AW-3]) begin
                  if (in_flag) pc <= pc + 1'b1;
                end else if (ar[AW-4]) begin
                  if (out_flag) pc <= pc + 1'b1;
                end else if (ar[AW-5]) int_en <= 1'b1;
                else if (ar[AW-6])     int_en <= 1'b0;
              end
            end
          endcase
        end
        S_INTR: begin
          pc     <= {{(AW-1){1'b0}}, 1'b1};
          int_en <= 1'b0;
          irq_r  <= 1'b0;
          state  <= S_FETCH;
        end
        S_HALT: ;
        default: state <= S_FETCH;
      endcase
      if (in_strobe) begin
        in_flag <= 1'b1;
        in_reg  <= in_data;
      end
      if (out_ack) out_flag <= 1'b1;
    end
  end

  // R2
  write_phase_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == S_EXEC || state == S_INTR));

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_we));

  // R10
  intr_save_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_INTR) |-> (mem_we && mem_addr == '0 && mem_wdata == pc_word));

  // R10
  intr_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_INTR) |=> (pc == {{(AW-1){1'b0}}, 1'b1} && !int_en && !irq_r));

  // R10
  irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_r) |-> $past(int_en));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE) |=> (pc == $past(pc) + 1'b1));
endmodule

// File: tb/acc_sequencer_test.sv
module acc_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we;
  logic [7:0]  in_data = 8'h00;
  logic        in_strobe = 1'b0;
  logic [7:0]  out_data;
  logic        out_ack = 1'b0;
  logic        halted;

  logic        ld_en = 1'b0;
  logic [9:0]  ld_a = '0;
  logic [15:0] ld_d = '0;
  logic [15:0] mem [1024];
  logic [15:0] img [1024];
  logic [15:0] rm  [1024];

  int nchk = 0;
  int nfail = 0;
  int last_cyc;

  logic [11:0] m_pc;
  logic [15:0] m_ac;
  logic [7:0]  m_inreg, m_out;
  logic        m_e, m_ien, m_fin, m_fout, m_irq, m_halt;

  always #2 clk = ~clk;

  acc_sequencer uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .in_strobe(in_strobe), .out_data(out_data), .out_ack(out_ack),
    .halted(halted)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic model_step(output int c);
    logic [15:0] w, v;
    logic [11:0] a;
    logic [2:0]  op;
    logic        ind, pre;
    if (m_irq) begin
      rm[0] = {4'h0, m_pc};
      m_pc = 12'h001; m_ien = 1'b0; m_irq = 1'b0; c = 2;
      return;
    end
    w = rm[m_pc[9:0]];
    m_pc = m_pc + 12'h001;
    ind = w[15]; op = w[14:12]; a = w[11:0];
    pre = m_ien && (m_fin || m_fout);
    if (op != 3'b111) begin
      c = 4;
      if (ind) begin a = rm[a[9:0]][11:0]; c = 6; end
      v = rm[a[9:0]];
      case (op)
        3'd0: m_ac = m_ac & v;
        3'd1: {m_e, m_ac} = {1'b0, m_ac} + {1'b0, v};
        3'd2: m_ac = v;
        3'd3: rm[a[9:0]] = m_ac;
        3'd4: m_pc = a;
        3'd5: begin rm[a[9:0]] = {4'h0, m_pc}; m_pc = a + 12'h001; end
        default: begin
          v = v + 16'h0001;
          rm[a[9:0]] = v;
          if (v == 16'h0000) m_pc = m_pc + 12'h001;
        end
      endcase
    end else begin
      c = 3;
      if (!ind) begin
        if (a[11])      m_ac = 16'h0000;
        else if (a[10]) m_e = 1'b0;
        else if (a[7])  begin {m_ac, m_e} = {m_e, m_ac}; end
        else if (a[6])  begin {m_e, m_ac} = {m_ac, m_e}; end
        else if (a[5])  m_ac = m_ac + 16'h0001;
        else if (a[0])  m_halt = 1'b1;
      end else begin
        if (a[11])      begin m_ac = {8'h00, m_inreg}; m_fin = 1'b0; end
        else if (a[10]) begin m_out = m_ac[7:0]; m_fout = 1'b0; end
        else if (a[9])  begin if (m_fin) m_pc = m_pc + 12'h001; end
        else if (a[8])  begin if (m_fout) m_pc = m_pc + 12'h001; end
        else if (a[7])  m_ien = 1'b1;
        else if (a[6])  m_ien = 1'b0;
      end
    end
    if (!m_halt) m_irq = m_irq | pre;
  endtask

  task automatic clear_img();
    for (int i = 0; i < 1024; i++) img[i] = 16'h0000;
  endtask

  task automatic run_case(input string tag, input bit s_in, input logic [7:0] din, input bit s_out);
    int exp_cyc, c, cyc, steps, bad, first;
    rst = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      ld_en = 1'b1; ld_a = 10'(i); ld_d = img[i]; rm[i] = img[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    m_pc = '0; m_ac = '0; m_e = 1'b0; m_ien = 1'b0; m_irq = 1'b0; m_halt = 1'b0;
    m_fin = s_in; m_fout = s_out; m_inreg = s_in ? din : 8'h00; m_out = 8'h00;
    exp_cyc = 0; steps = 0;
    while (!m_halt && steps < 2000) begin
      model_step(c);
      exp_cyc += c; steps++;
    end
    rst = 1'b0; in_strobe = s_in; in_data = din; out_ack = s_out;
    cyc = 0;
    while (1) begin
      @(posedge clk); @(negedge clk);
      in_strobe = 1'b0; out_ack = 1'b0;
      cyc++;
      if (halted || cyc >= 4000) break;
    end
    last_cyc = cyc;
    // R7 halt reached, R2/R3 instruction costs summed
    chk(halted == 1'b1, {tag, " R7 halt reached"}, int'(halted), 1);
    chk(cyc == exp_cyc, {tag, " R2 R3 clock count"}, cyc, exp_cyc);
    bad = 0; first = 0;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== rm[i]) begin if (bad == 0) first = i; bad++; end
    chk(bad == 0, {tag, " R2 memory image"}, int'(mem[first]), int'(rm[first]));
    // R8 output port
    chk(out_data == m_out, {tag, " R8 out_data"}, int'(out_data), int'(m_out));
    bad = 0;
    repeat (6) begin
      @(posedge clk); @(negedge clk);
      if (mem_we || !halted) bad++;
    end
    chk(bad == 0, {tag, " R7 halt holds, no write"}, bad, 0);
  endtask

  function automatic logic [15:0] rand_instr();
    int r;
    logic ind;
    logic [2:0] op;
    logic [11:0] a;
    logic [15:0] ctl [12] = '{16'h7800, 16'h7400, 16'h7020, 16'h7080, 16'h7040,
                              16'hF800, 16'hF400, 16'hF200, 16'hF100, 16'hF080,
                              16'hF040, 16'hF080};
    logic [2:0] mops [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6};
    r = int'($urandom % 17);
    if (r < 5) begin
      op  = mops[r];
      ind = 1'($urandom % 2);
      a   = ind ? 12'h200 + 12'($urandom % 4) : 12'h100 + 12'($urandom % 8);
      return {ind, op, a};
    end
    return ctl[r - 5];
  endfunction

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int len;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(mem_addr == 12'h000, "R1 fetch address after reset", int'(mem_addr), 0);
    chk(mem_we == 1'b0, "R1 no write in reset", int'(mem_we), 0);
    chk(halted == 1'b0, "R1 halted clear", int'(halted), 0);
    chk(out_data == 8'h00, "R1 out_data clear", int'(out_data), 0);

    // R2 direct memory ops
    clear_img();
    img[0] = 16'h2100; img[1] = 16'h1101; img[2] = 16'h0102; img[3] = 16'h3103; img[4] = 16'h7001;
    img[12'h100] = 16'h1234; img[12'h101] = 16'h0F0F; img[12'h102] = 16'hFF00;
    run_case("direct", 1'b0, 8'h00, 1'b0);
    chk(mem[12'h103] == 16'h2100, "R2 load-add-and-store", int'(mem[12'h103]), 16'h2100);
    chk(last_cyc == 19, "R2 four clocks per direct op", last_cyc, 19);

    // R1 accumulator cleared by reset after a prior run
    clear_img();
    img[0] = 16'h3100; img[1] = 16'h7001; img[12'h100] = 16'hBEEF;
    run_case("reset-ac", 1'b0, 8'h00, 1'b0);
    chk(mem[12'h100] == 16'h0000, "R1 accumulator zero after reset", int'(mem[12'h100]), 0);

    // R3 indirect
    clear_img();
    img[0] = 16'hA200; img[1] = 16'hB201; img[2] = 16'h7001;
    img[12'h200] = 16'h0105; img[12'h201] = 16'h0106; img[12'h105] = 16'h5A5A;
    run_case("indirect", 1'b0, 8'h00, 1'b0);
    chk(mem[12'h106] == 16'h5A5A, "R3 indirect load and store", int'(mem[12'h106]), 16'h5A5A);
    chk(last_cyc == 15, "R3 six clocks per indirect op", last_cyc, 15);

    // R4 call and return
    clear_img();
    img[0] = 16'h5030; img[1] = 16'h3100; img[2] = 16'h7001;
    img[12'h031] = 16'h2101; img[12'h032] = 16'hC030; img[12'h101] = 16'h0777;
    run_case("call", 1'b0, 8'h00, 1'b0);
    chk(mem[12'h030] == 16'h0001, "R4 return address saved", int'(mem[12'h030]), 1);
    chk(mem[12'h100] == 16'h0777, "R4 returned to caller", int'(mem[12'h100]), 16'h0777);

    // R5 increment and skip loop
    clear_img();
    img[0] = 16'h6100; img[1] = 16'h4000; img[2] = 16'h7001; img[12'h100] = 16'hFFFD;
    run_case("incskip", 1'b0, 8'h00, 1'b0);
    chk(mem[12'h100] == 16'h0000, "R5 counter reached zero", int'(mem[12'h100]), 0);
    chk(last_cyc == 23, "R5 loop clock count", last_cyc, 23);

    // R6 accumulator control words
    clear_img();
    img[0] = 16'h2100; img[1] = 16'h7040; img[2] = 16'h3101; img[3] = 16'h7080;
    img[4] = 16'h3102; img[5] = 16'h7800; img[6] = 16'h7020; img[7] = 16'h3103;
    img[8] = 16'h1104; img[9] = 16'h7400; img[10] = 16'h7080; img[11] = 16'h3105;
    img[12] = 16'h7001;
    img[12'h100] = 16'h8001; img[12'h104] = 16'hFFFF; img[12'h105] = 16'h1111;
    run_case("control", 1'b0, 8'h00, 1'b0);
    chk(mem[12'h101] == 16'h0002, "R6 rotate left", int'(mem[12'h101]), 2);
    chk(mem[12'h102] == 16'h8001, "R6 rotate right", int'(mem[12'h102]), 16'h8001);
    chk(mem[12'h103] == 16'h0001, "R6 clear then increment", int'(mem[12'h103]), 1);
    chk(mem[12'h105] == 16'h0000, "R6 carry cleared", int'(mem[12'h105]), 0);

    // R8 R9 ports and flag skips
    clear_img();
    img[0] = 16'hF200; img[1] = 16'h7001; img[2] = 16'hF800; img[3] = 16'hF400;
    img[4] = 16'hF100; img[5] = 16'h3100; img[6] = 16'h7001;
    run_case("ports", 1'b1, 8'hA5, 1'b1);
    chk(out_data == 8'hA5, "R8 byte passed to output", int'(out_data), 16'hA5);
    chk(mem[12'h100] == 16'h00A5, "R9 skip taken then output flag cleared", int'(mem[12'h100]), 16'hA5);

    // R10 interrupt entry
    clear_img();
    img[0] = 16'h4010; img[1] = 16'h30F0; img[2] = 16'h7001;
    img[12'h010] = 16'h2100; img[12'h011] = 16'hF080; img[12'h012] = 16'h2101; img[12'h013] = 16'h7001;
    img[12'h101] = 16'h4242;
    run_case("interrupt", 1'b1, 8'h11, 1'b0);
    chk(mem[0] == 16'h0013, "R10 saved program counter", int'(mem[0]), 16'h13);
    chk(mem[12'h0F0] == 16'h4242, "R10 vectored handler ran", int'(mem[12'h0F0]), 16'h4242);

    // random straight-line programs, R2..R10
    for (int t = 0; t < 25; t++) begin
      clear_img();
      img[0] = 16'h4010; img[1] = 16'h30F0; img[2] = 16'h7001;
      for (int k = 0; k < 8; k++) img[12'h100 + k] = 16'($urandom);
      for (int k = 0; k < 4; k++) img[12'h200 + k] = 16'h0100 + 16'($urandom % 8);
      len = 10 + int'($urandom % 15);
      for (int k = 0; k < len; k++) img[12'h010 + k] = rand_instr();
      img[12'h010 + len] = 16'h30F1;
      img[12'h011 + len] = 16'h7001;
      img[12'h012 + len] = 16'h7001;
      run_case("random", 1'($urandom % 2), 8'($urandom), 1'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule